// File: doc/BRIEF.md
# Host/Firmware Ownership Mailbox

This block is a small register bank that a host CPU and an embedded controller CPU share as a message channel. Each side has its own register port. Both ports see the same registers at the same offsets. Each port carries a write strobe, an address and write data. Read data is combinational from the registers, so a read takes no cycles.

The host posts a message into the inbound data register. The firmware posts into the outbound data register. A command register holds an interrupt enable and four destination selects, and the interrupt outputs follow it. An ownership register decides which side may post a normal message. A side claims the mailbox by writing its ID while the owner is none. It gives the mailbox back by writing none. Acknowledge and negative-acknowledge messages may be posted without holding ownership.

A status register records a firmware hang event next to an enable bit. The firmware side sets these bits and the host side clears them by writing ones. Register writes are always accepted in the cycle they are presented. There is no back-pressure: a write whose guard fails is dropped silently, and the writer sees this by reading the register back.

Top module: `hostfw_mailbox`

## Requirements
- R1: After reset every register reads 0 on both ports (owner none) and all five interrupt outputs are low.
- R2: The owner register is bits 7:0 at offset 0x0F0, encoded 0 = none, 1 = firmware, 2 = software. Writing a nonzero ID takes effect only when the owner is none; otherwise the owner is unchanged. Writing 0 from either port sets none. Bits 31:8 read 0.
- R3: If both ports write the owner register in the same cycle, the host write is applied and the firmware write is dropped.
- R4: A message word has its type in bits 31:24 and its payload in bits 23:0; type 128 is acknowledge and 129 is negative acknowledge. Only the host port writes inbound data (0x0E8), and only while the owner is 2 or the type is 128/129. Only the firmware port writes outbound data (0x0EC), and only while the owner is 1 or the type is 128/129. Any other write leaves the register unchanged.
- R5: The command register (0x0E4) stores bits 31..27 from a full-word write; all other bits read 0. If both ports write it in the same cycle, the host value is taken.
- R6: With bit 31 as interrupt enable, irq_xhci = b31&b30, irq_host = b31&b29, irq_pme = b31&b28 and irq_cpu = b31&b27. These outputs change the cycle after the write edge.
- R7: An accepted write of owner none clears command bit 27 on the same edge, even if a command write in that cycle sets it. Command bits 31..28 are kept.
- R8: Status register (0x428): bit 1 = hang, bit 3 = enable. A fw_hang pulse or a firmware-port write of 1 sets a bit. A host-port write of 1 clears it. Set wins over clear in the same cycle. Other bits read 0. irq_fault = bit1 & bit3.
- R9: Both ports read every register at the offsets above. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host port write strobe |
| h_addr | input | 12 | Host port register offset |
| h_wdata | input | 32 | Host port write data |
| h_rdata | output | 32 | Host port read data (combinational) |
| f_we | input | 1 | Firmware port write strobe |
| f_addr | input | 12 | Firmware port register offset |
| f_wdata | input | 32 | Firmware port write data |
| f_rdata | output | 32 | Firmware port read data (combinational) |
| fw_hang | input | 1 | One-cycle pulse that flags a firmware hang |
| irq_cpu | output | 1 | Message interrupt to the controller CPU |
| irq_host | output | 1 | Message interrupt to the host (SMI destination) |
| irq_xhci | output | 1 | xHCI destination interrupt |
| irq_pme | output | 1 | PME destination interrupt |
| irq_fault | output | 1 | Hang flagged while the enable bit is set |

## Verification
The bench runs the ownership claim from every starting owner with every small ID, and it drives same-cycle claims from both ports. A design that lets a claim overwrite a held mailbox, or that lets the firmware win a tie, shows a wrong owner on readback. It sweeps all 256 message types into an unowned mailbox, so an ownership bypass open to any type other than 128/129 leaves changed data. It walks all 32 command-bit patterns against the four destination outputs. It also covers two collisions. The first is a release that meets a command write setting bit 27: if the release does not win, a stale CPU interrupt remains. The second is a hang pulse that meets a host clear: if the clear wins, the hang event is lost.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [11:0] OFS_CMD  = 12'h0E4;
  localparam logic [11:0] OFS_DIN  = 12'h0E8;
  localparam logic [11:0] OFS_DOUT = 12'h0EC;
  localparam logic [11:0] OFS_OWN  = 12'h0F0;
  localparam logic [11:0] OFS_SMI  = 12'h428;

  localparam logic [7:0] OWN_NONE = 8'd0;
  localparam logic [7:0] OWN_FW   = 8'd1;
  localparam logic [7:0] OWN_SW   = 8'd2;
  localparam logic [7:0] TYPE_ACK = 8'd128;
  localparam logic [7:0] TYPE_NAK = 8'd129;

  localparam int CMD_BITS = 5;
  localparam int ST_HANG  = 1;
  localparam int ST_EN    = 3;

  typedef struct packed {
    logic cmd;
    logic din;
    logic dout;
    logic own;
    logic smi;
  } mbox_sel_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mbox_sel_t         hit_o,
  output mbox_sel_t         wsel_o
);
  always_comb begin
    hit_o.cmd  = (addr_i == ADDR_W'(OFS_CMD));
    hit_o.din  = (addr_i == ADDR_W'(OFS_DIN));
    hit_o.dout = (addr_i == ADDR_W'(OFS_DOUT));
    hit_o.own  = (addr_i == ADDR_W'(OFS_OWN));
    hit_o.smi  = (addr_i == ADDR_W'(OFS_SMI));
    wsel_o     = we_i ? hit_o : '0;
  end
endmodule

// File: rtl/mbox_owner.sv
module mbox_owner
  import mbox_pkg::*;
#(
  parameter int OWN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we_i,
  input  logic [OWN_W-1:0] h_val_i,
  input  logic             f_we_i,
  input  logic [OWN_W-1:0] f_val_i,
  output logic [OWN_W-1:0] owner_o,
  output logic             release_o
);
  logic [OWN_W-1:0] q, nxt;
  logic             wr;
  logic [OWN_W-1:0] val;

  // host port has priority when both write in one cycle
  always_comb begin
    wr  = h_we_i | f_we_i;
    val = h_we_i ? h_val_i : f_val_i;
    nxt = q;
    release_o = 1'b0;
    if (wr) begin
      if (val == '0) begin
        nxt       = '0;
        release_o = 1'b1;
      end else if (q == '0) begin
        nxt = val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign owner_o = q;

  p_claim_from_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((q != $past(q)) && (q != '0)) |-> ($past(q) == '0));

  p_host_wins_tie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(h_we_i && f_we_i && (h_val_i != '0) && (q == '0)) |-> (q == $past(h_val_i)));
endmodule

// File: rtl/mbox_cmd.sv
module mbox_cmd
  import mbox_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                h_we_i,
  input  logic [CMD_BITS-1:0] h_val_i,
  input  logic                f_we_i,
  input  logic [CMD_BITS-1:0] f_val_i,
  input  logic                release_i,
  output logic [CMD_BITS-1:0] bits_o,
  output logic                irq_cpu_o,
  output logic                irq_host_o,
  output logic                irq_xhci_o,
  output logic                irq_pme_o
);
  // bit order: 4 enable, 3 xhci, 2 smi, 1 pme, 0 controller cpu
  localparam int B_IE = 4, B_XHCI = 3, B_SMI = 2, B_PME = 1, B_CPU = 0;

  logic [CMD_BITS-1:0] q, nxt;

  always_comb begin
    if (h_we_i)      nxt = h_val_i;
    else if (f_we_i) nxt = f_val_i;
    else             nxt = q;
    if (release_i) nxt[B_CPU] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign bits_o     = q;
  assign irq_cpu_o  = q[B_IE] & q[B_CPU];
  assign irq_host_o = q[B_IE] & q[B_SMI];
  assign irq_xhci_o = q[B_IE] & q[B_XHCI];
  assign irq_pme_o  = q[B_IE] & q[B_PME];

  p_release_drops_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(release_i) |-> !irq_cpu_o);

  p_release_keeps_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(release_i && !h_we_i && !f_we_i) |-> (q[B_IE:B_PME] == $past(q[B_IE:B_PME])));
endmodule

// File: rtl/mbox_smistat.sv
module mbox_smistat (
  input  logic clk,
  input  logic rst_n,
  input  logic hang_i,
  input  logic set_we_i,
  input  logic set_hang_i,
  input  logic set_en_i,
  input  logic clr_we_i,
  input  logic clr_hang_i,
  input  logic clr_en_i,
  output logic hang_o,
  output logic en_o,
  output logic fault_o
);
  logic hang_q, en_q;
  logic hang_set, hang_clr, en_set, en_clr;

  always_comb begin
    hang_set = hang_i | (set_we_i & set_hang_i);
    hang_clr = clr_we_i & clr_hang_i;
    en_set   = set_we_i & set_en_i;
    en_clr   = clr_we_i & clr_en_i;
  end

  // set beats clear so an event in the clearing cycle survives
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hang_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      hang_q <= hang_set | (hang_q & ~hang_clr);
      en_q   <= en_set   | (en_q   & ~en_clr);
    end
  end

  assign hang_o  = hang_q;
  assign en_o    = en_q;
  assign fault_o = hang_q & en_q;

  p_hang_not_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hang_i) |-> hang_o);

  p_clear_only_by_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hang_o) |-> $past(clr_we_i && clr_hang_i));
endmodule

// File: rtl/hostfw_mailbox.sv
module hostfw_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int OWN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              f_we,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [DATA_W-1:0] f_wdata,
  output logic [DATA_W-1:0] f_rdata,
  input  logic              fw_hang,
  output logic              irq_cpu,
  output logic              irq_host,
  output logic              irq_xhci,
  output logic              irq_pme,
  output logic              irq_fault
);
  localparam int NPORT    = 2;
  localparam int TYPE_W   = 8;
  localparam int TYPE_LSB = DATA_W - TYPE_W;
  localparam int CMD_LSB  = DATA_W - CMD_BITS;

  logic              p_we   [NPORT];
  logic [ADDR_W-1:0] p_addr [NPORT];
  logic [DATA_W-1:0] p_rd   [NPORT];
  mbox_sel_t         p_hit  [NPORT];
  mbox_sel_t         p_wsel [NPORT];

  logic [OWN_W-1:0]    owner_q;
  logic                owner_rel;
  logic [DATA_W-1:0]   din_q, dout_q;
  logic [CMD_BITS-1:0] cmd_bits;
  logic                st_hang, st_en;
  logic [DATA_W-1:0]   cmd_word, stat_word, own_word;
  logic                din_ok, dout_ok;

  assign p_we[0]   = h_we;
  assign p_we[1]   = f_we;
  assign p_addr[0] = h_addr;
  assign p_addr[1] = f_addr;
  assign h_rdata   = p_rd[0];
  assign f_rdata   = p_rd[1];

  function automatic logic is_ack(input logic [TYPE_W-1:0] t);
    return (t == TYPE_ACK) || (t == TYPE_NAK);
  endfunction

  function automatic logic [DATA_W-1:0] rmux(
    input mbox_sel_t h, input logic [DATA_W-1:0] c, input logic [DATA_W-1:0] di,
    input logic [DATA_W-1:0] dq, input logic [DATA_W-1:0] o, input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] r;
    r = '0;
    if (h.cmd)  r = c;
    if (h.din)  r = di;
    if (h.dout) r = dq;
    if (h.own)  r = o;
    if (h.smi)  r = s;
    return r;
  endfunction

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      mbox_decode #(.ADDR_W(ADDR_W)) u_dec (
        .we_i   (p_we[p]),
        .addr_i (p_addr[p]),
        .hit_o  (p_hit[p]),
        .wsel_o (p_wsel[p])
      );
      assign p_rd[p] = rmux(p_hit[p], cmd_word, din_q, dout_q, own_word, stat_word);
    end
  endgenerate

  mbox_owner #(.OWN_W(OWN_W)) u_own (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_we_i    (p_wsel[0].own),
    .h_val_i   (h_wdata[OWN_W-1:0]),
    .f_we_i    (p_wsel[1].own),
    .f_val_i   (f_wdata[OWN_W-1:0]),
    .owner_o   (owner_q),
    .release_o (owner_rel)
  );

  mbox_cmd u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_we_i     (p_wsel[0].cmd),
    .h_val_i    (h_wdata[DATA_W-1:CMD_LSB]),
    .f_we_i     (p_wsel[1].cmd),
    .f_val_i    (f_wdata[DATA_W-1:CMD_LSB]),
    .release_i  (owner_rel),
    .bits_o     (cmd_bits),
    .irq_cpu_o  (irq_cpu),
    .irq_host_o (irq_host),
    .irq_xhci_o (irq_xhci),
    .irq_pme_o  (irq_pme)
  );

  mbox_smistat u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .hang_i     (fw_hang),
    .set_we_i   (p_wsel[1].smi),
    .set_hang_i (f_wdata[ST_HANG]),
    .set_en_i   (f_wdata[ST_EN]),
    .clr_we_i   (p_wsel[0].smi),
    .clr_hang_i (h_wdata[ST_HANG]),
    .clr_en_i   (h_wdata[ST_EN]),
    .hang_o     (st_hang),
    .en_o       (st_en),
    .fault_o    (irq_fault)
  );

  always_comb begin
    cmd_word            = {cmd_bits, {CMD_LSB{1'b0}}};
    own_word            = DATA_W'(owner_q);
    stat_word           = '0;
    stat_word[ST_HANG]  = st_hang;
    stat_word[ST_EN]    = st_en;
  end

  // ownership guard on the two message registers, ack/nak bypass it
  assign din_ok  = p_wsel[0].din &&
                   ((owner_q == OWN_W'(OWN_SW)) || is_ack(h_wdata[TYPE_LSB +: TYPE_W]));
  assign dout_ok = p_wsel[1].dout &&
                   ((owner_q == OWN_W'(OWN_FW)) || is_ack(f_wdata[TYPE_LSB +: TYPE_W]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q  <= '0;
      dout_q <= '0;
    end else begin
      if (din_ok)  din_q  <= h_wdata;
      if (dout_ok) dout_q <= f_wdata;
    end
  end

  p_din_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (din_q != $past(din_q)) |->
      ($past(h_we) && ($past(h_addr) == ADDR_W'(OFS_DIN)) &&
       (($past(owner_q) == OWN_W'(OWN_SW)) || is_ack($past(h_wdata[TYPE_LSB +: TYPE_W])))));

  p_dout_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_q != $past(dout_q)) |->
      ($past(f_we) && ($past(f_addr) == ADDR_W'(OFS_DOUT)) &&
       (($past(owner_q) == OWN_W'(OWN_FW)) || is_ack($past(f_wdata[TYPE_LSB +: TYPE_W])))));
endmodule

// File: tb/sim_hostfw_mailbox.sv
module sim_hostfw_mailbox;
  localparam logic [11:0] A_CMD = 12'h0E4, A_DIN = 12'h0E8, A_DOUT = 12'h0EC,
                          A_OWN = 12'h0F0, A_SMI = 12'h428;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, h_we, f_we, fw_hang;
  logic [11:0] h_addr, f_addr;
  logic [31:0] h_wdata, f_wdata, h_rdata, f_rdata;
  logic        irq_cpu, irq_host, irq_xhci, irq_pme, irq_fault;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  hostfw_mailbox u0 (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .f_we(f_we), .f_addr(f_addr), .f_wdata(f_wdata), .f_rdata(f_rdata),
    .fw_hang(fw_hang), .irq_cpu(irq_cpu), .irq_host(irq_host),
    .irq_xhci(irq_xhci), .irq_pme(irq_pme), .irq_fault(irq_fault)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(bit fw, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    if (fw) begin f_we = 1; f_addr = a; f_wdata = d; end
    else    begin h_we = 1; h_addr = a; h_wdata = d; end
    @(negedge clk);
    h_we = 0; f_we = 0;
  endtask

  task automatic wr2(logic [11:0] ha, logic [31:0] hd, logic [11:0] fa, logic [31:0] fd);
    @(negedge clk);
    h_we = 1; h_addr = ha; h_wdata = hd;
    f_we = 1; f_addr = fa; f_wdata = fd;
    @(negedge clk);
    h_we = 0; f_we = 0;
  endtask

  task automatic rd(bit fw, logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    if (fw) f_addr = a; else h_addr = a;
    #1 d = fw ? f_rdata : h_rdata;
  endtask

  function automatic logic [31:0] irqs();
    return {27'd0, irq_fault, irq_xhci, irq_host, irq_pme, irq_cpu};
  endfunction

  task automatic set_owner(logic [7:0] v);
    wr(0, A_OWN, 32'd0);
    if (v != 0) wr(0, A_OWN, {24'd0, v});
  endtask

  initial begin
    logic [31:0] x, exp_din, exp_dout;
    rst_n = 0; h_we = 0; f_we = 0; fw_hang = 0;
    h_addr = 0; f_addr = 0; h_wdata = 0; f_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, A_CMD, x);  chk("R1 cmd", x, 0);
    rd(0, A_DIN, x);  chk("R1 din", x, 0);
    rd(1, A_DOUT, x); chk("R1 dout", x, 0);
    rd(1, A_OWN, x);  chk("R1 owner", x, 0);
    rd(0, A_SMI, x);  chk("R1 status", x, 0);
    chk("R1 irqs", irqs(), 0);

    // R2 claim sweep from each start owner, host port
    for (int s = 0; s < 3; s++) begin
      for (int hv = 0; hv < 4; hv++) begin
        set_owner(8'(s));
        wr(0, A_OWN, 32'hFFFF_FF00 | 32'(hv));
        rd(1, A_OWN, x);
        chk("R2 claim", x, (hv == 0) ? 0 : ((s == 0) ? hv : s));
      end
    end
    // R2 release from firmware port
    set_owner(8'd2);
    wr(1, A_OWN, 32'd0);
    rd(0, A_OWN, x); chk("R2 fw release", x, 0);

    // R3 tie: host wins
    for (int hv = 1; hv < 4; hv++) begin
      for (int fv = 1; fv < 4; fv++) begin
        set_owner(8'd0);
        wr2(A_OWN, 32'(hv), A_OWN, 32'(fv));
        rd(0, A_OWN, x); chk("R3 tie", x, hv);
      end
    end

    // R4 type sweep with owner none
    set_owner(8'd0);
    exp_din = 0;
    for (int t = 0; t < 256; t++) begin
      logic [31:0] d;
      d = {8'(t), 24'(t * 7 + 3)};
      wr(0, A_DIN, d);
      if (t == 128 || t == 129) exp_din = d;
      rd(1, A_DIN, x); chk("R4 din type sweep", x, exp_din);
    end
    set_owner(8'd2);
    wr(0, A_DIN, 32'h0512_3456); exp_din = 32'h0512_3456;
    rd(1, A_DIN, x); chk("R4 din owned", x, exp_din);
    wr(1, A_DIN, 32'h8000_0001);
    rd(0, A_DIN, x); chk("R4 din fw port ignored", x, exp_din);
    exp_dout = 0;
    wr(1, A_DOUT, 32'h0700_0011);
    rd(0, A_DOUT, x); chk("R4 dout not owned", x, exp_dout);
    wr(1, A_DOUT, 32'h8100_0022); exp_dout = 32'h8100_0022;
    rd(0, A_DOUT, x); chk("R4 dout nak bypass", x, exp_dout);
    wr(0, A_DOUT, 32'h8000_0033);
    rd(0, A_DOUT, x); chk("R4 dout host port ignored", x, exp_dout);
    set_owner(8'd0); wr(1, A_OWN, 32'd1);
    wr(1, A_DOUT, 32'h0900_0044); exp_dout = 32'h0900_0044;
    rd(0, A_DOUT, x); chk("R4 dout fw owned", x, exp_dout);
    set_owner(8'd0);

    // R5 / R6 command bits and destination interrupts
    for (int v = 0; v < 32; v++) begin
      logic ie;
      wr(0, A_CMD, (32'(v) << 27) | 32'h0555_AAAA);
      rd(1, A_CMD, x); chk("R5 cmd bits", x, 32'(v) << 27);
      ie = v[4];
      chk("R6 irqs", irqs(), {27'd0, 1'b0, ie & v[3], ie & v[2], ie & v[1], ie & v[0]});
    end
    wr2(A_CMD, 32'h4000_0000, A_CMD, 32'h2000_0000);
    rd(0, A_CMD, x); chk("R5 host wins cmd", x, 32'h4000_0000);

    // R7 release clears controller-cpu bit
    set_owner(8'd2);
    wr(0, A_CMD, 32'hA800_0000);
    chk("R7 irq_cpu raised", {31'd0, irq_cpu}, 1);
    wr(1, A_OWN, 32'd0);
    rd(0, A_CMD, x); chk("R7 release keeps upper", x, 32'hA000_0000);
    chk("R7 irqs after release", irqs(), 32'h4);
    set_owner(8'd2);
    wr2(A_CMD, 32'h8800_0000, A_OWN, 32'd0);
    rd(0, A_CMD, x); chk("R7 release beats set", x, 32'h8000_0000);
    rd(0, A_OWN, x); chk("R7 owner none", x, 0);
    wr(0, A_CMD, 32'd0);

    // R8 status set/clear
    @(negedge clk); fw_hang = 1; @(negedge clk); fw_hang = 0;
    rd(0, A_SMI, x); chk("R8 hang pulse", x, 32'h2);
    chk("R8 no fault w/o enable", {31'd0, irq_fault}, 0);
    wr(1, A_SMI, 32'hFFFF_FFF8);
    rd(0, A_SMI, x); chk("R8 fw sets enable", x, 32'hA);
    chk("R8 fault", {31'd0, irq_fault}, 1);
    wr(0, A_SMI, 32'h2);
    rd(1, A_SMI, x); chk("R8 host w1c", x, 32'h8);
    @(negedge clk);
    fw_hang = 1; h_we = 1; h_addr = A_SMI; h_wdata = 32'h2;
    @(negedge clk); fw_hang = 0; h_we = 0;
    rd(0, A_SMI, x); chk("R8 set beats clear", x, 32'hA);
    wr(0, A_SMI, 32'hFFFF_FFFF);
    rd(0, A_SMI, x); chk("R8 host clears all", x, 0);

    // R9 unmapped offsets
    wr(0, 12'h0F4, 32'hFFFF_FFFF);
    wr(1, 12'h000, 32'hFFFF_FFFF);
    rd(0, 12'h0F4, x); chk("R9 unmapped read", x, 0);
    rd(1, 12'h000, x); chk("R9 unmapped read fw", x, 0);
    rd(0, A_CMD, x);   chk("R9 cmd untouched", x, 0);
    rd(1, A_DIN, x);   chk("R9 din untouched", x, exp_din);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all) got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule